// File: doc/BRIEF.md
# Registered Inverting Bus Transceiver

This block moves data between two 8-bit ports, A and B, in either direction. Each port has a capture register, so a word can be held and sent later instead of passed straight through. An active-low output enable and a direction input decide which port, if any, is driven. For each direction, a select input picks what goes out on the driven port. It is either the live input of the opposite port or the word that port's register last captured. Every value that leaves the block is the bitwise complement of the selected source.

Each tri-state pin is modelled as three signals: an input vector, an output vector and one output-enable bit per port. Captures use a single system clock. The A-side register loads the port A input on any clock edge where its capture strobe is high, and the B-side register does the same with the port B input. Capture is independent of the output controls, so words can be collected while both ports are isolated. The live paths are purely combinational. A driven port's output is computed only from the other port's input vector, so no loop runs through a driven pin.

Top module: `inv_bus_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both capture registers to zero. After reset, a port driven from stored data shows all ones.
- R2: On a rising clock edge with `cap_a` high, the A-side register takes `a_in`. With `cap_a` low, it keeps its value.
- R3: On a rising clock edge with `cap_b` high, the B-side register takes `b_in`. With `cap_b` low, it keeps its value.
- R4: Capture ignores `oe_n` and `dir`. Words loaded while outputs are isolated, or while a port is being driven, later appear on the outputs.
- R5: With `oe_n` = 1, `a_oe` and `b_oe` are both 0.
- R6: With `oe_n` = 0 and `dir` = 0, `a_oe` = 1 and `b_oe` = 0, so port A is driven.
- R7: With `oe_n` = 0 and `dir` = 1, `b_oe` = 1 and `a_oe` = 0, so port B is driven.
- R8: While B is driven, `b_out` is `~a_in` in the same cycle when `sel_ab` = 0, and `~` the A-side register when `sel_ab` = 1.
- R9: While A is driven, `a_out` is `~b_in` in the same cycle when `sel_ba` = 0, and `~` the B-side register when `sel_ba` = 1.
- R10: At most one of `a_oe` and `b_oe` is high at any time.
- R11: A port whose enable is low has an output vector of all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; registers capture on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cap_a | input | 1 | Load the A-side register from `a_in` |
| cap_b | input | 1 | Load the B-side register from `b_in` |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 0 drives port A, 1 drives port B |
| sel_ab | input | 1 | Source for port B: 0 live `a_in`, 1 stored A word |
| sel_ba | input | 1 | Source for port A: 0 live `b_in`, 1 stored B word |
| a_in | input | WIDTH | Port A pin input value |
| a_out | output | WIDTH | Port A pin drive value |
| a_oe | output | 1 | Port A pin drive enable |
| b_in | input | WIDTH | Port B pin input value |
| b_out | output | WIDTH | Port B pin drive value |
| b_oe | output | 1 | Port B pin drive enable |

## Verification
The bench loads registers while outputs are isolated and then reads them back through the stored path. A design that gated capture with the output enable would show stale words there. It visits all 16 combinations of `oe_n`, `dir` and both selects. This catches a swapped direction decode, selects wired to the wrong direction, and a missing inversion, which would show the true value instead of the complement. Random cycles change the live input and strobe capture in the same cycle. A design that registered the live path, or that fed the stored path from the live input, would then be one word out of step.

// File: rtl/inv_bus_xcvr_pkg.sv
package inv_bus_xcvr_pkg;
  typedef enum logic {
    DRIVE_A = 1'b0,
    DRIVE_B = 1'b1
  } drive_side_e;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_kind_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  AST_CAPTURE_TAKES_D: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d))); // R2, R3
  AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R2, R3
endmodule

// File: rtl/xcvr_dir_decode.sv
module xcvr_dir_decode
  import inv_bus_xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir,
  output logic a_en,
  output logic b_en
);
  drive_side_e side;

  always_comb begin
    side = drive_side_e'(dir);
    a_en = !oe_n && (side == DRIVE_A);
    b_en = !oe_n && (side == DRIVE_B);
  end
endmodule

// File: rtl/xcvr_port_drive.sv
module xcvr_port_drive
  import inv_bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  logic             use_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out
);
  src_kind_e           kind;
  logic [WIDTH-1:0]    picked;

  always_comb begin
    kind   = src_kind_e'(use_stored);
    picked = (kind == SRC_STORED) ? stored : live;
    out    = en ? ~picked : '0;
  end
endmodule

// File: rtl/inv_bus_xcvr.sv
module inv_bus_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [WIDTH-1:0] held_a;
  logic [WIDTH-1:0] held_b;

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_hold_a (
    .clk(clk), .rst(rst), .load(cap_a), .d(a_in), .q(held_a)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_hold_b (
    .clk(clk), .rst(rst), .load(cap_b), .d(b_in), .q(held_b)
  );

  xcvr_dir_decode u_decode (
    .oe_n(oe_n), .dir(dir), .a_en(a_oe), .b_en(b_oe)
  );

  // Port B is fed only from port A's input or register, never from b_in.
  xcvr_port_drive #(.WIDTH(WIDTH)) u_drive_b (
    .en(b_oe), .use_stored(sel_ab), .live(a_in), .stored(held_a), .out(b_out)
  );

  // Port A is fed only from port B's input or register, never from a_in.
  xcvr_port_drive #(.WIDTH(WIDTH)) u_drive_a (
    .en(a_oe), .use_stored(sel_ba), .live(b_in), .stored(held_b), .out(a_out)
  );

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $countones({a_oe, b_oe}) <= 1); // R10
  AST_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe)); // R5
  AST_B_LIVE_INV: assert property (@(posedge clk) disable iff (rst)
    (b_oe && !sel_ab) |-> (b_out == ~a_in)); // R8
  AST_A_LIVE_INV: assert property (@(posedge clk) disable iff (rst)
    (a_oe && !sel_ba) |-> (a_out == ~b_in)); // R9
  AST_QUIET_A: assert property (@(posedge clk) disable iff (rst)
    !a_oe |-> (a_out == '0)); // R11
  AST_QUIET_B: assert property (@(posedge clk) disable iff (rst)
    !b_oe |-> (b_out == '0)); // R11
endmodule

// File: tb/inv_bus_xcvr_test.sv
module inv_bus_xcvr_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cap_a = 0, cap_b = 0, oe_n = 1, dir = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] m_a = '0, m_b = '0;

  always #2 clk = ~clk;

  inv_bus_xcvr #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .cap_a(cap_a), .cap_b(cap_b), .oe_n(oe_n),
    .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [W-1:0] exp_b_out();
    if (oe_n || !dir) return '0;
    return sel_ab ? ~m_a : ~a_in;
  endfunction

  function automatic logic [W-1:0] exp_a_out();
    if (oe_n || dir) return '0;
    return sel_ba ? ~m_b : ~b_in;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (oe_n=%b dir=%b sel_ab=%b sel_ba=%b)",
               req, act, exp, oe_n, dir, sel_ab, sel_ba);
    end
  endtask

  task automatic check_all();
    string ra, rb;
    if (oe_n)     begin ra = "R5"; rb = "R5"; end
    else if (dir) begin ra = "R7"; rb = "R7"; end
    else          begin ra = "R6"; rb = "R6"; end
    chk(ra, {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, !oe_n && !dir});
    chk(rb, {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, !oe_n && dir});
    chk("R10", {{(W-1){1'b0}}, a_oe && b_oe}, '0);
    chk(a_oe ? "R9" : "R11", a_out, exp_a_out());
    chk(b_oe ? "R8" : "R11", b_out, exp_b_out());
  endtask

  // Drive at negedge, check, then let the posedge capture and update the model.
  task automatic step(input logic ca, input logic cb, input logic on, input logic d,
                      input logic sab, input logic sba,
                      input logic [W-1:0] av, input logic [W-1:0] bv);
    @(negedge clk);
    cap_a = ca; cap_b = cb; oe_n = on; dir = d; sel_ab = sab; sel_ba = sba;
    a_in = av; b_in = bv;
    #1;
    check_all();
    @(posedge clk);
    if (cap_a) m_a = a_in;
    if (cap_b) m_b = b_in;
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    // R1: reset clears both registers.
    // The stored paths then show all ones.
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    oe_n = 0; dir = 1; sel_ab = 1;
    #1;
    chk("R1", b_out, {W{1'b1}});
    @(negedge clk);
    dir = 0; sel_ba = 1;
    #1;
    chk("R1", a_out, {W{1'b1}});

    // R4: capture both registers during isolation, with changing controls.
    step(1, 1, 1, 0, 0, 0, 8'h3C, 8'hA5);
    step(0, 0, 1, 1, 1, 1, 8'h00, 8'hFF);
    // R2/R4: the stored A word drives port B.
    step(0, 0, 0, 1, 1, 0, 8'h77, 8'h11);
    chk("R4", b_out, ~8'h3C);
    // R3/R4: the stored B word drives port A.
    step(0, 0, 0, 0, 0, 1, 8'h55, 8'h66);
    chk("R4", a_out, ~8'hA5);

    // R4: capture port B while port B is being driven.
    step(0, 1, 0, 1, 0, 0, 8'h12, 8'hC3);
    step(0, 0, 0, 0, 0, 1, 8'h00, 8'h00);
    chk("R3", a_out, ~8'hC3);

    // R2: hold with the strobe low.
    step(0, 0, 0, 1, 1, 0, 8'hEE, 8'hEE);
    chk("R2", b_out, ~8'h3C);

    // All 16 combinations of the four control inputs, with live data.
    for (int k = 0; k < 16; k++) begin
      step(0, 0, k[0], k[1], k[2], k[3], 8'h5A ^ 8'(k), 8'hC6 + 8'(k));
    end

    // Random mix of controls, strobes and data.
    for (int n = 0; n < 400; n++) begin
      step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule